// File: doc/BRIEF.md
# Register-Pair Doubleword Load/Store Unit

This unit carries out one 64-bit load or store on a 32-bit core. The 64-bit value lives in an even/odd pair of general registers. A decoder outside the block supplies four things with a one-cycle start strobe: a base register value, a zero-extended immediate that is already a multiple of 8, the pair's register index, and a store flag. The unit adds the immediate to the base to form the address. It then runs two 32-bit beats on a request/ready memory port, low word first.

On a load, both returned words are held inside the unit. They are written back together through two register-file write ports, in the same cycle as the one-cycle done pulse. On a store, both registers are read at start and their words are sent on the two beats. Three conditions end the operation with an error pulse instead of done:

- an odd pair index (illegal instruction),
- an address not aligned to 8 bytes (misaligned),
- a bus error on either beat.

Top module: `pairLsu`

## Requirements
- R1: The effective address is `baseVal + zero-extended immVal`. The first beat requests that address and the second beat requests it plus 4. Both beats are requested in that order, and every requested address has bits 1:0 equal to zero.
- R2: On a load, the word from the first beat is written to the even register (`pairIdx` with bit 0 cleared, on `rfWaddrLo`). The word from the second beat is written to the odd register (bit 0 set, on `rfWaddrHi`). Both writes happen in the single cycle in which `done` is high.
- R3: On a store, the first beat carries the even register's value and the second beat carries the odd register's value. Both values are read through `rfRaddrLo`/`rfRaddrHi` in the start cycle. `memWe` is high on both beats of a store and low on both beats of a load.
- R4: A start with `pairIdx` bit 0 set raises `errIllegal` for one cycle in the following cycle, and no memory request is made.
- R5: A start with an even pair whose effective address has any of bits 2:0 set raises `errMisalign` for one cycle in the following cycle, and no memory request is made. When both conditions hold, only `errIllegal` is raised.
- R6: A beat that completes with `memErr` high raises `errBus` for one cycle in the following cycle, and the unit returns to idle. If it was the first beat, no second beat is requested. No register write is made.
- R7: A load to pair 0 writes only the odd register x1; the write to x0 is dropped (`rfWeLo` stays low).
- R8: `done` is high for exactly one cycle, in the cycle after the second beat completes without error, and the unit is idle (`busy` low) in that cycle. At most one of `done`, `errIllegal`, `errMisalign`, `errBus` is high in any cycle.
- R9: A start strobe that arrives while `busy` is high is ignored and does not disturb the operation in progress.
- R10: While `memReq` is high and `memReady` is low, `memReq`, `memAddr`, `memWe` and `memWdata` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startVld | input | 1 | One-cycle start strobe |
| isStore | input | 1 | 1 = store pair, 0 = load pair |
| baseVal | input | 32 | Base register value |
| immVal | input | 9 | Zero-extended byte offset |
| pairIdx | input | 5 | Register index of the pair (even index expected) |
| busy | output | 1 | A memory operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| errIllegal | output | 1 | One-cycle odd-pair error pulse |
| errMisalign | output | 1 | One-cycle alignment error pulse |
| errBus | output | 1 | One-cycle bus error pulse |
| memReq | output | 1 | Beat request |
| memWe | output | 1 | Beat is a write |
| memAddr | output | 32 | Beat byte address |
| memWdata | output | 32 | Beat write data |
| memReady | input | 1 | Beat completes this cycle |
| memRdata | input | 32 | Read data, valid with memReady |
| memErr | input | 1 | Beat error, valid with memReady |
| rfRaddrLo | output | 5 | Even register read index |
| rfRaddrHi | output | 5 | Odd register read index |
| rfRdataLo | input | 32 | Even register read value |
| rfRdataHi | input | 32 | Odd register read value |
| rfWeLo | output | 1 | Even register write enable |
| rfWaddrLo | output | 5 | Even register write index |
| rfWdataLo | output | 32 | Even register write data |
| rfWeHi | output | 1 | Odd register write enable |
| rfWaddrHi | output | 5 | Odd register write index |
| rfWdataHi | output | 32 | Odd register write data |

## Verification
If the sequencer is in the wrong phase, the fault shows at the memory port in the same cycle. The request appears or vanishes, or carries an address 4 bytes off, and the bench model flags this at once. A wrongly latched address, store word or pair index shows on the first beat or on the commit cycle. A lost first load word only shows when both registers are written, one cycle after the second beat. For that reason, every load is followed by a read-back of the pair, and bus errors are injected on each beat separately. The error paths return to idle in one cycle, so a wrong priority or a missing pulse is visible in the cycle right after the start.

// File: rtl/pairLsuPkg.sv
package pairLsuPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } lsuState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;     // latch address, pair index, store words
    logic selHi;       // address/data of the second beat
    logic latchLo;     // keep the first loaded word
    logic commitLoad;  // second beat finished cleanly
    logic pulseDone;
    logic pulseIll;
    logic pulseMis;
    logic pulseBus;
  } lsuCtl_t;

endpackage

// File: rtl/pairLsuCtrl.sv
module pairLsuCtrl
  import pairLsuPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startVld,
  input  logic    oddPair,
  input  logic    misaligned,
  input  logic    memReady,
  input  logic    memErr,
  output lsuCtl_t ctl,
  output logic    memReq,
  output logic    busy
);

  lsuState_e state, stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (startVld) begin
          if (oddPair)         ctl.pulseIll = 1'b1;
          else if (misaligned) ctl.pulseMis = 1'b1;
          else begin
            ctl.capture = 1'b1;
            stateNext   = ST_LO;
          end
        end
      end
      ST_LO: begin
        if (memReady) begin
          if (memErr) begin
            ctl.pulseBus = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            ctl.latchLo = 1'b1;
            stateNext   = ST_HI;
          end
        end
      end
      ST_HI: begin
        ctl.selHi = 1'b1;
        if (memReady) begin
          stateNext = ST_IDLE;
          if (memErr) ctl.pulseBus = 1'b1;
          else begin
            ctl.commitLoad = 1'b1;
            ctl.pulseDone  = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq = (state == ST_LO) || (state == ST_HI);
  assign busy   = memReq;

endmodule

// File: rtl/pairLsuDpath.sv
module pairLsuDpath
  import pairLsuPkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 9,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  lsuCtl_t          ctl,
  input  logic             isStore,
  input  logic [XLEN-1:0]  baseVal,
  input  logic [IMM_W-1:0] immVal,
  input  logic [REG_W-1:0] pairIdx,
  input  logic [XLEN-1:0]  rfRdataLo,
  input  logic [XLEN-1:0]  rfRdataHi,
  input  logic [XLEN-1:0]  memRdata,
  output logic             oddPair,
  output logic             misaligned,
  output logic             memWe,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  output logic [REG_W-1:0] rfRaddrLo,
  output logic [REG_W-1:0] rfRaddrHi,
  output logic             rfWeLo,
  output logic [REG_W-1:0] rfWaddrLo,
  output logic [XLEN-1:0]  rfWdataLo,
  output logic             rfWeHi,
  output logic [REG_W-1:0] rfWaddrHi,
  output logic [XLEN-1:0]  rfWdataHi,
  output logic             done,
  output logic             errIllegal,
  output logic             errMisalign,
  output logic             errBus
);

  localparam int BEAT_BYTES = XLEN / 8;
  localparam int PAIR_BYTES = 2 * BEAT_BYTES;
  localparam int ALIGN_W    = $clog2(PAIR_BYTES);
  localparam int PAIR_W     = REG_W - 1;

  logic [XLEN-1:0]   effAddr;
  logic [XLEN-1:0]   addrQ;
  logic              storeQ;
  logic [PAIR_W-1:0] pairQ;
  logic [XLEN-1:0]   sdLoQ, sdHiQ, ldLoQ;

  assign effAddr    = baseVal + XLEN'(immVal);
  assign misaligned = |effAddr[ALIGN_W-1:0];
  assign oddPair    = pairIdx[0];

  assign rfRaddrLo = {pairIdx[REG_W-1:1], 1'b0};
  assign rfRaddrHi = {pairIdx[REG_W-1:1], 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      storeQ <= 1'b0;
      pairQ  <= '0;
      sdLoQ  <= '0;
      sdHiQ  <= '0;
      ldLoQ  <= '0;
    end else begin
      if (ctl.capture) begin
        addrQ  <= effAddr;
        storeQ <= isStore;
        pairQ  <= pairIdx[REG_W-1:1];
        sdLoQ  <= rfRdataLo;
        sdHiQ  <= rfRdataHi;
      end
      if (ctl.latchLo && !storeQ) ldLoQ <= memRdata;
    end
  end

  assign memAddr  = addrQ + (ctl.selHi ? XLEN'(BEAT_BYTES) : '0);
  assign memWe    = storeQ;
  assign memWdata = ctl.selHi ? sdHiQ : sdLoQ;

  // write-back and status pulses are registered
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rfWeLo      <= 1'b0;
      rfWeHi      <= 1'b0;
      rfWaddrLo   <= '0;
      rfWaddrHi   <= '0;
      rfWdataLo   <= '0;
      rfWdataHi   <= '0;
      done        <= 1'b0;
      errIllegal  <= 1'b0;
      errMisalign <= 1'b0;
      errBus      <= 1'b0;
    end else begin
      rfWeLo      <= ctl.commitLoad && !storeQ && (pairQ != '0);
      rfWeHi      <= ctl.commitLoad && !storeQ;
      if (ctl.commitLoad) begin
        rfWaddrLo <= {pairQ, 1'b0};
        rfWaddrHi <= {pairQ, 1'b1};
        rfWdataLo <= ldLoQ;
        rfWdataHi <= memRdata;
      end
      done        <= ctl.pulseDone;
      errIllegal  <= ctl.pulseIll;
      errMisalign <= ctl.pulseMis;
      errBus      <= ctl.pulseBus;
    end
  end

endmodule

// File: rtl/pairLsu.sv
module pairLsu
  import pairLsuPkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 9,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startVld,
  input  logic             isStore,
  input  logic [XLEN-1:0]  baseVal,
  input  logic [IMM_W-1:0] immVal,
  input  logic [REG_W-1:0] pairIdx,
  output logic             busy,
  output logic             done,
  output logic             errIllegal,
  output logic             errMisalign,
  output logic             errBus,
  output logic             memReq,
  output logic             memWe,
  output logic [XLEN-1:0]  memAddr,
  output logic [XLEN-1:0]  memWdata,
  input  logic             memReady,
  input  logic [XLEN-1:0]  memRdata,
  input  logic             memErr,
  output logic [REG_W-1:0] rfRaddrLo,
  output logic [REG_W-1:0] rfRaddrHi,
  input  logic [XLEN-1:0]  rfRdataLo,
  input  logic [XLEN-1:0]  rfRdataHi,
  output logic             rfWeLo,
  output logic [REG_W-1:0] rfWaddrLo,
  output logic [XLEN-1:0]  rfWdataLo,
  output logic             rfWeHi,
  output logic [REG_W-1:0] rfWaddrHi,
  output logic [XLEN-1:0]  rfWdataHi
);

  lsuCtl_t ctl;
  logic    oddPair, misaligned;

  pairLsuCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startVld   (startVld),
    .oddPair    (oddPair),
    .misaligned (misaligned),
    .memReady   (memReady),
    .memErr     (memErr),
    .ctl        (ctl),
    .memReq     (memReq),
    .busy       (busy)
  );

  pairLsuDpath #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_W(REG_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .isStore     (isStore),
    .baseVal     (baseVal),
    .immVal      (immVal),
    .pairIdx     (pairIdx),
    .rfRdataLo   (rfRdataLo),
    .rfRdataHi   (rfRdataHi),
    .memRdata    (memRdata),
    .oddPair     (oddPair),
    .misaligned  (misaligned),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .rfRaddrLo   (rfRaddrLo),
    .rfRaddrHi   (rfRaddrHi),
    .rfWeLo      (rfWeLo),
    .rfWaddrLo   (rfWaddrLo),
    .rfWdataLo   (rfWdataLo),
    .rfWeHi      (rfWeHi),
    .rfWaddrHi   (rfWaddrHi),
    .rfWdataHi   (rfWdataHi),
    .done        (done),
    .errIllegal  (errIllegal),
    .errMisalign (errMisalign),
    .errBus      (errBus)
  );

endmodule

// File: rtl/pairLsuChk.sv
module pairLsuChk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 9,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             startVld,
  input logic [XLEN-1:0]  baseVal,
  input logic [IMM_W-1:0] immVal,
  input logic [REG_W-1:0] pairIdx,
  input logic             busy,
  input logic             done,
  input logic             errIllegal,
  input logic             errMisalign,
  input logic             errBus,
  input logic             memReq,
  input logic             memWe,
  input logic [XLEN-1:0]  memAddr,
  input logic [XLEN-1:0]  memWdata,
  input logic             memReady,
  input logic             rfWeLo,
  input logic [REG_W-1:0] rfWaddrLo,
  input logic             rfWeHi
);

  logic [2:0] lowSum;
  assign lowSum = baseVal[2:0] + immVal[2:0];

  AST_BEAT_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[1:0] == 2'b00)); // R1

  AST_WRITE_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (rfWeLo || rfWeHi) |-> done); // R2

  AST_ODD_PAIR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (startVld && !busy && pairIdx[0]) |=> (errIllegal && !memReq)); // R4

  AST_MISALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (startVld && !busy && !pairIdx[0] && (lowSum != 3'd0)) |=> (errMisalign && !memReq)); // R5

  AST_BUS_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    errBus |-> !(rfWeLo || rfWeHi)); // R6

  AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rfWeLo |-> (rfWaddrLo != '0)); // R7

  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $countones({done, errIllegal, errMisalign, errBus}) <= 1); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata))); // R10

endmodule

bind pairLsu pairLsuChk #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_W(REG_W)) uChk (.*);

// File: tb/tb_pairLsu.sv
`timescale 1ns/1ps
module tb_pairLsu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startVld = 1'b0, isStore = 1'b0;
  logic [31:0] baseVal = '0;
  logic [8:0]  immVal = '0;
  logic [4:0]  pairIdx = '0;
  logic        busy, done, errIllegal, errMisalign, errBus;
  logic        memReq, memWe, memReady, memErr;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [4:0]  rfRaddrLo, rfRaddrHi, rfWaddrLo, rfWaddrHi;
  logic [31:0] rfRdataLo, rfRdataHi, rfWdataLo, rfWdataHi;
  logic        rfWeLo, rfWeHi;

  always #5 clk = ~clk;

  pairLsu dut (.*);

  logic [31:0] rf [32];
  logic [31:0] mem [64];
  logic [31:0] errAddr = 32'hFFFF_FFF0;
  logic        slowMode = 1'b0;
  logic [7:0]  lf = 8'h5B;

  assign rfRdataLo = (rfRaddrLo == 5'd0) ? 32'd0 : rf[rfRaddrLo];
  assign rfRdataHi = rf[rfRaddrHi];
  assign memRdata  = mem[memAddr[7:2]];
  assign memErr    = memReq && (memAddr == errAddr);

  int errors = 0, checks = 0, cyc = 0;
  int nDone = 0, nIll = 0, nMis = 0, nBus = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // behavioural reference model, updated every clock
  int          mPh = 0;
  logic [31:0] mAddr, mSLo, mSHi, mLoRd;
  bit          mStore;
  logic [4:0]  mIdx;
  bit          eDone, eIll, eMis, eBus, eWeLo, eWeHi;
  logic [31:0] eWdLo, eWdHi;
  logic [4:0]  eWaLo, eWaHi;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 0);
      finishRun();
    end
    eDone = 0; eIll = 0; eMis = 0; eBus = 0; eWeLo = 0; eWeHi = 0;
    if (!rstN) mPh = 0;
    else begin
      case (mPh)
        0: if (startVld) begin
          if (pairIdx[0]) eIll = 1;
          else if (((baseVal + {23'd0, immVal}) & 32'd7) != 0) eMis = 1;
          else begin
            mPh = 1; mAddr = baseVal + {23'd0, immVal}; mStore = isStore;
            mIdx = pairIdx; mSLo = (pairIdx == 0) ? 32'd0 : rf[pairIdx]; mSHi = rf[pairIdx + 5'd1];
          end
        end
        1: if (memReady) begin
          if (mAddr == errAddr) begin eBus = 1; mPh = 0; end
          else begin mLoRd = mem[(mAddr >> 2) & 63]; mPh = 2; end
        end
        default: if (memReady) begin
          mPh = 0;
          if (mAddr + 4 == errAddr) eBus = 1;
          else begin
            eDone = 1;
            if (!mStore) begin
              eWeHi = 1; eWeLo = (mIdx != 0);
              eWaLo = mIdx; eWaHi = mIdx + 5'd1;
              eWdLo = mLoRd; eWdHi = mem[((mAddr + 4) >> 2) & 63];
            end
          end
        end
      endcase
    end
    if (rfWeLo) rf[rfWaddrLo] = rfWdataLo;
    if (rfWeHi) rf[rfWaddrHi] = rfWdataHi;
    if (memReq && memReady && memWe && !memErr) mem[memAddr[7:2]] = memWdata;
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(memReq == (mPh != 0), "R1 memReq", memReq, mPh != 0);
      check(busy == (mPh != 0), "R9 busy", busy, mPh != 0);
      if (memReq && mPh != 0) begin
        check(memAddr == mAddr + ((mPh == 2) ? 32'd4 : 32'd0), "R1 memAddr", memAddr,
              mAddr + ((mPh == 2) ? 32'd4 : 32'd0));
        check(memWe == mStore, "R3 memWe", memWe, mStore);
        if (mStore)
          check(memWdata == ((mPh == 1) ? mSLo : mSHi), "R3 memWdata", memWdata,
                (mPh == 1) ? mSLo : mSHi);
      end
      check(done == eDone, "R8 done", done, eDone);
      check(errIllegal == eIll, "R4 errIllegal", errIllegal, eIll);
      check(errMisalign == eMis, "R5 errMisalign", errMisalign, eMis);
      check(errBus == eBus, "R6 errBus", errBus, eBus);
      check(rfWeHi == eWeHi, "R2 rfWeHi", rfWeHi, eWeHi);
      check(rfWeLo == eWeLo, "R7 rfWeLo", rfWeLo, eWeLo);
      if (eWeHi && rfWeHi) begin
        check(rfWaddrHi == eWaHi, "R2 rfWaddrHi", rfWaddrHi, eWaHi);
        check(rfWdataHi == eWdHi, "R2 rfWdataHi", rfWdataHi, eWdHi);
      end
      if (eWeLo && rfWeLo) begin
        check(rfWaddrLo == eWaLo, "R2 rfWaddrLo", rfWaddrLo, eWaLo);
        check(rfWdataLo == eWdLo, "R2 rfWdataLo", rfWdataLo, eWdLo);
      end
      nDone += done; nIll += errIllegal; nMis += errMisalign; nBus += errBus;
    end
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    memReady = slowMode ? (lf[0] & lf[2]) | lf[5] : 1'b1;
  end

  task automatic doOp(input bit st, input logic [31:0] b, input logic [8:0] im,
                      input logic [4:0] idx, input bit dup);
    @(negedge clk);
    startVld = 1; isStore = st; baseVal = b; immVal = im; pairIdx = idx;
    @(negedge clk);
    startVld = 0;
    if (dup) begin
      startVld = 1; isStore = !st; pairIdx = idx ^ 5'd2; baseVal = 32'h30; immVal = 9'd0;
      @(negedge clk);
      startVld = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = (i == 0) ? 32'd0 : (32'hA500_0000 ^ (i * 32'h0101_0101));
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i * 32'h111;
    memReady = 1'b1;
    repeat (3) @(negedge clk);
    check(!memReq && !busy && !done && !rfWeLo && !rfWeHi, "R8 reset state", {memReq, busy, done}, 0);
    rstN = 1'b1;

    // R2 basic load: address 0x18
    doOp(0, 32'h10, 9'h08, 5'd4, 0);
    check(rf[4] == mem[6], "R2 even reg", rf[4], mem[6]);
    check(rf[5] == mem[7], "R2 odd reg", rf[5], mem[7]);

    // R3 store pair 6 to 0x40
    doOp(1, 32'h20, 9'h20, 5'd6, 0);
    check(mem[16] == rf[6], "R3 low word", mem[16], rf[6]);
    check(mem[17] == rf[7], "R3 high word", mem[17], rf[7]);

    // R4 odd pair, R5 misaligned, priority
    doOp(0, 32'h10, 9'h08, 5'd3, 0);
    check(nIll == 1, "R4 illegal pulse count", nIll, 1);
    doOp(1, 32'h14, 9'h00, 5'd8, 0);
    check(nMis == 1, "R5 misaligned pulse count", nMis, 1);
    doOp(0, 32'h13, 9'h00, 5'd9, 0);
    check(nIll == 2 && nMis == 1, "R5 illegal has priority", {nIll[15:0], nMis[15:0]}, {16'd2, 16'd1});

    // R6 bus error on low beat, then high beat
    errAddr = 32'h50;
    doOp(0, 32'h50, 9'h00, 5'd10, 0);
    check(rf[10] == (32'hA500_0000 ^ (10 * 32'h0101_0101)), "R6 lo err reg kept", rf[10],
          32'hA500_0000 ^ (10 * 32'h0101_0101));
    errAddr = 32'h5C;
    doOp(0, 32'h58, 9'h00, 5'd12, 0);
    check(rf[13] == (32'hA500_0000 ^ (13 * 32'h0101_0101)), "R6 hi err reg kept", rf[13],
          32'hA500_0000 ^ (13 * 32'h0101_0101));
    check(nBus == 2, "R6 bus pulse count", nBus, 2);
    errAddr = 32'hFFFF_FFF0;

    // R7 pair 0 load
    doOp(0, 32'h0, 9'h08, 5'd0, 0);
    check(rf[0] == 32'd0, "R7 x0 untouched", rf[0], 0);
    check(rf[1] == mem[3], "R7 x1 written", rf[1], mem[3]);

    // R9 start while busy, R10 with slow memory
    slowMode = 1'b1;
    doOp(0, 32'h80, 9'h38, 5'd14, 1);
    check(rf[14] == mem[46] && rf[15] == mem[47], "R9 busy start ignored", rf[14], mem[46]);
    for (int k = 0; k < 12; k++)
      doOp(k[0], 32'h40 + k * 8, 9'(k * 16), 5'(2 * (k % 15) + 2), k[1]);

    check(nDone == 16, "R8 done pulse count", nDone, 16);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule